// File: doc/BRIEF.md
# Register Window Control Unit

This block keeps the bookkeeping for a windowed integer register file. It holds the current-window pointer and four window counters. The counters track how many windows may still be saved, how many may be restored, how many are known clean, and how many belong to another context. It also holds a pair of 3-bit trap-vector selectors. A request strobe carries one of five operations: save, restore, return, flush-windows, or a state load. On the clock edge that samples the strobe, the unit updates the pointer and the counters. From the next cycle on, it shows a one-cycle response with a trap kind and vector, or a write-enable for the destination register.

The register storage, the address adder and the trap dispatch sit outside this block. For a return, the caller passes only the two low bits of the computed target. The number of windows is the parameter `NWIN`, which must be at least 3. The pointer and all counters are `$clog2(NWIN)` bits wide.

Top module: `regwin_ctl`

## Requirements
- R1: While reset is low and after it is released: pointer 0, save-count NWIN-2, restore-count 0, clean-count NWIN-2, other-count 0, selectors 0, and no response.
- R2: Save with save-count nonzero and clean-count different from restore-count moves the pointer up by one modulo NWIN, decrements save-count, increments restore-count, and raises rdWrite with trap kind 0.
- R3: Save with save-count zero gives a spill trap and moves the pointer up by two modulo NWIN, leaving the counters unchanged. The kind is 2 (spill-other) when other-count is nonzero, else 1 (spill-normal).
- R4: Save with save-count nonzero and clean-count equal to restore-count gives trap kind 5 (clean) and moves the pointer up by one, leaving the counters unchanged.
- R5: Restore always moves the pointer down by one modulo NWIN. With restore-count zero it gives a fill trap: kind 4 (fill-other) when other-count is nonzero, else 3 (fill-normal), counters unchanged. Otherwise it increments save-count, decrements restore-count and raises rdWrite.
- R6: Return whose tgtLow is nonzero gives trap kind 6 (alignment) and leaves all state unchanged, even when a fill would also apply. With tgtLow zero it behaves exactly as restore.
- R7: Flush-windows never changes state. It gives a spill trap, with the kind chosen as in R3, when NWIN-2 minus save-count is nonzero, and trap kind 0 otherwise.
- R8: trapVec carries ldWstate bits [2:0] (normal selector) for kinds 1 and 3, bits [5:3] (other selector) for kinds 2 and 4, and 0 for every other kind.
- R9: Load (op 4) copies all six load inputs into the state and gives a response with trap kind 0 and no rdWrite.
- R10: With reqValid low, or with an op code of 5 to 7, there is no response and no state changes.
- R11: The response (rspValid, rdWrite, trapKind, trapVec) is valid exactly in the cycle after the request edge. rdWrite is never high together with a nonzero trap kind. Op codes: 0 save, 1 restore, 2 return, 3 flush-windows, 4 load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, one operation per cycle |
| reqOp | input | 3 | Operation code |
| tgtLow | input | 2 | Two low bits of the return target |
| ldCwp | input | CW | Pointer value for load |
| ldCanSave | input | CW | Save-count value for load |
| ldCanRestore | input | CW | Restore-count value for load |
| ldCleanWin | input | CW | Clean-count value for load |
| ldOtherWin | input | CW | Other-count value for load |
| ldWstate | input | 6 | Selectors for load: [5:3] other, [2:0] normal |
| cwp | output | CW | Current-window pointer |
| canSave | output | CW | Save-count |
| canRestore | output | CW | Restore-count |
| cleanWin | output | CW | Clean-count |
| otherWin | output | CW | Other-count |
| wstate | output | 6 | Trap-vector selectors |
| rspValid | output | 1 | Response valid |
| rdWrite | output | 1 | Destination register write enable |
| trapKind | output | 3 | Trap kind, 0 when none |
| trapVec | output | 3 | Selector chosen for a spill or fill |

## Verification
A return can meet the alignment check and the fill condition in the same cycle. The bench provokes this by issuing a return with a misaligned target while restore-count is zero and other-count is nonzero. It then requires the alignment kind with the pointer unchanged; a fill-other trap or a pointer step down would be wrong. A save can also meet a zero save-count and an equal clean and restore count in the same cycle, and there the spill must win and the pointer must advance by two.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  typedef enum logic [2:0] {
    OP_SAVE    = 3'd0,
    OP_RESTORE = 3'd1,
    OP_RETURN  = 3'd2,
    OP_FLUSH   = 3'd3,
    OP_LOAD    = 3'd4
  } win_op_e;

  typedef enum logic [2:0] {
    TK_NONE    = 3'd0,
    TK_SPILL_N = 3'd1,
    TK_SPILL_O = 3'd2,
    TK_FILL_N  = 3'd3,
    TK_FILL_O  = 3'd4,
    TK_CLEAN   = 3'd5,
    TK_ALIGN   = 3'd6
  } trap_kind_e;

  typedef enum logic [1:0] {
    CM_HOLD = 2'd0,
    CM_INC1 = 2'd1,
    CM_INC2 = 2'd2,
    CM_DEC1 = 2'd3
  } cwp_mv_e;

  typedef enum logic [1:0] {
    KM_HOLD    = 2'd0,
    KM_SAVE    = 2'd1,
    KM_RESTORE = 2'd2
  } ctr_mv_e;

  typedef enum logic [1:0] {
    VS_NONE   = 2'd0,
    VS_NORMAL = 2'd1,
    VS_OTHER  = 2'd2
  } vec_sel_e;

  typedef struct packed {
    logic       rsp;
    logic       load;
    logic       rdWr;
    cwp_mv_e    cwpMv;
    ctr_mv_e    ctrMv;
    trap_kind_e kind;
    vec_sel_e   vecSel;
  } win_strobe_t;

endpackage

// File: rtl/regwin_decide.sv
module regwin_decide
  import regwin_pkg::*;
(
  input  logic        reqValid,
  input  logic [2:0]  reqOp,
  input  logic [1:0]  tgtLow,
  input  logic        saveZero,
  input  logic        restoreZero,
  input  logic        cleanEqRestore,
  input  logic        otherNz,
  input  logic        flushClear,
  output win_strobe_t strobe
);

  win_strobe_t restoreStrobe;

  always_comb begin
    restoreStrobe        = '0;
    restoreStrobe.rsp    = 1'b1;
    restoreStrobe.cwpMv  = CM_DEC1;
    if (restoreZero) begin
      restoreStrobe.kind   = otherNz ? TK_FILL_O : TK_FILL_N;
      restoreStrobe.vecSel = otherNz ? VS_OTHER : VS_NORMAL;
    end else begin
      restoreStrobe.ctrMv = KM_RESTORE;
      restoreStrobe.rdWr  = 1'b1;
    end
  end

  always_comb begin
    strobe = '0;
    if (reqValid) begin
      case (reqOp)
        OP_SAVE: begin
          strobe.rsp = 1'b1;
          if (saveZero) begin
            strobe.cwpMv  = CM_INC2;
            strobe.kind   = otherNz ? TK_SPILL_O : TK_SPILL_N;
            strobe.vecSel = otherNz ? VS_OTHER : VS_NORMAL;
          end else if (cleanEqRestore) begin
            strobe.cwpMv = CM_INC1;
            strobe.kind  = TK_CLEAN;
          end else begin
            strobe.cwpMv = CM_INC1;
            strobe.ctrMv = KM_SAVE;
            strobe.rdWr  = 1'b1;
          end
        end
        OP_RESTORE: strobe = restoreStrobe;
        OP_RETURN: begin
          if (tgtLow != 2'b00) begin
            strobe.rsp  = 1'b1;
            strobe.kind = TK_ALIGN;
          end else begin
            strobe = restoreStrobe;
          end
        end
        OP_FLUSH: begin
          strobe.rsp = 1'b1;
          if (!flushClear) begin
            strobe.kind   = otherNz ? TK_SPILL_O : TK_SPILL_N;
            strobe.vecSel = otherNz ? VS_OTHER : VS_NORMAL;
          end
        end
        OP_LOAD: begin
          strobe.rsp  = 1'b1;
          strobe.load = 1'b1;
        end
        default: strobe = '0;
      endcase
    end
  end

endmodule

// File: rtl/regwin_state.sv
module regwin_state
  import regwin_pkg::*;
#(
  parameter int NWIN = 8,
  localparam int CW = $clog2(NWIN)
) (
  input  logic          clk,
  input  logic          rstN,
  input  win_strobe_t   strobe,
  input  logic [CW-1:0] ldCwp,
  input  logic [CW-1:0] ldCanSave,
  input  logic [CW-1:0] ldCanRestore,
  input  logic [CW-1:0] ldCleanWin,
  input  logic [CW-1:0] ldOtherWin,
  input  logic [5:0]    ldWstate,
  output logic [CW-1:0] cwp,
  output logic [CW-1:0] canSave,
  output logic [CW-1:0] canRestore,
  output logic [CW-1:0] cleanWin,
  output logic [CW-1:0] otherWin,
  output logic [5:0]    wstate,
  output logic          saveZero,
  output logic          restoreZero,
  output logic          cleanEqRestore,
  output logic          otherNz,
  output logic          flushClear,
  output logic          rspValid,
  output logic          rdWrite,
  output logic [2:0]    trapKind,
  output logic [2:0]    trapVec
);

  localparam logic [CW-1:0] LAST     = CW'(NWIN - 1);
  localparam logic [CW-1:0] SAVE_TOP = CW'(NWIN - 2);
  localparam logic [CW:0]   WRAP     = (CW + 1)'(NWIN);

  logic [CW-1:0] cwpNext;
  logic [CW:0]   cwpPlus2;
  logic [2:0]    vecNext;

  always_comb begin
    cwpPlus2 = {1'b0, cwp} + (CW + 1)'(2);
    if (cwpPlus2 >= WRAP) cwpPlus2 = cwpPlus2 - WRAP;
    case (strobe.cwpMv)
      CM_INC1: cwpNext = (cwp == LAST) ? '0 : cwp + 1'b1;
      CM_INC2: cwpNext = cwpPlus2[CW-1:0];
      CM_DEC1: cwpNext = (cwp == '0) ? LAST : cwp - 1'b1;
      default: cwpNext = cwp;
    endcase
  end

  always_comb begin
    case (strobe.vecSel)
      VS_NORMAL: vecNext = wstate[2:0];
      VS_OTHER:  vecNext = wstate[5:3];
      default:   vecNext = 3'd0;
    endcase
  end

  assign saveZero       = (canSave == '0);
  assign restoreZero    = (canRestore == '0);
  assign cleanEqRestore = (cleanWin == canRestore);
  assign otherNz        = (otherWin != '0);
  assign flushClear     = (canSave == SAVE_TOP);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cwp        <= '0;
      canSave    <= SAVE_TOP;
      canRestore <= '0;
      cleanWin   <= SAVE_TOP;
      otherWin   <= '0;
      wstate     <= '0;
    end else if (strobe.load) begin
      cwp        <= ldCwp;
      canSave    <= ldCanSave;
      canRestore <= ldCanRestore;
      cleanWin   <= ldCleanWin;
      otherWin   <= ldOtherWin;
      wstate     <= ldWstate;
    end else begin
      cwp <= cwpNext;
      case (strobe.ctrMv)
        KM_SAVE: begin
          canSave    <= canSave - 1'b1;
          canRestore <= canRestore + 1'b1;
        end
        KM_RESTORE: begin
          canSave    <= canSave + 1'b1;
          canRestore <= canRestore - 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rdWrite  <= 1'b0;
      trapKind <= 3'd0;
      trapVec  <= 3'd0;
    end else begin
      rspValid <= strobe.rsp;
      rdWrite  <= strobe.rdWr;
      trapKind <= strobe.kind;
      trapVec  <= (strobe.load) ? 3'd0 : vecNext;
    end
  end

  // R11
  rdwr_no_trap_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdWrite |-> (trapKind == 3'd0) && rspValid);

  // R10
  quiet_no_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> !rdWrite && (trapKind == 3'd0));

  // R8
  vec_only_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trapKind == 3'd0 || trapKind == 3'd5 || trapKind == 3'd6) |-> (trapVec == 3'd0));

endmodule

// File: rtl/regwin_ctl.sv
module regwin_ctl
  import regwin_pkg::*;
#(
  parameter int NWIN = 8,
  localparam int CW = $clog2(NWIN)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic [2:0]    reqOp,
  input  logic [1:0]    tgtLow,
  input  logic [CW-1:0] ldCwp,
  input  logic [CW-1:0] ldCanSave,
  input  logic [CW-1:0] ldCanRestore,
  input  logic [CW-1:0] ldCleanWin,
  input  logic [CW-1:0] ldOtherWin,
  input  logic [5:0]    ldWstate,
  output logic [CW-1:0] cwp,
  output logic [CW-1:0] canSave,
  output logic [CW-1:0] canRestore,
  output logic [CW-1:0] cleanWin,
  output logic [CW-1:0] otherWin,
  output logic [5:0]    wstate,
  output logic          rspValid,
  output logic          rdWrite,
  output logic [2:0]    trapKind,
  output logic [2:0]    trapVec
);

  localparam logic [CW-1:0] LAST = CW'(NWIN - 1);

  win_strobe_t strobe;
  logic saveZero, restoreZero, cleanEqRestore, otherNz, flushClear;

  regwin_decide u_decide (
    .reqValid       (reqValid),
    .reqOp          (reqOp),
    .tgtLow         (tgtLow),
    .saveZero       (saveZero),
    .restoreZero    (restoreZero),
    .cleanEqRestore (cleanEqRestore),
    .otherNz        (otherNz),
    .flushClear     (flushClear),
    .strobe         (strobe)
  );

  regwin_state #(.NWIN(NWIN)) u_state (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .ldCwp          (ldCwp),
    .ldCanSave      (ldCanSave),
    .ldCanRestore   (ldCanRestore),
    .ldCleanWin     (ldCleanWin),
    .ldOtherWin     (ldOtherWin),
    .ldWstate       (ldWstate),
    .cwp            (cwp),
    .canSave        (canSave),
    .canRestore     (canRestore),
    .cleanWin       (cleanWin),
    .otherWin       (otherWin),
    .wstate         (wstate),
    .saveZero       (saveZero),
    .restoreZero    (restoreZero),
    .cleanEqRestore (cleanEqRestore),
    .otherNz        (otherNz),
    .flushClear     (flushClear),
    .rspValid       (rspValid),
    .rdWrite        (rdWrite),
    .trapKind       (trapKind),
    .trapVec        (trapVec)
  );

  // R6
  align_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqOp == 3'd2 && tgtLow != 2'b00
    |=> (trapKind == 3'd6) && (cwp == $past(cwp)) && (canRestore == $past(canRestore)));

  // R3
  spill_save_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqOp == 3'd0 && canSave == '0
    |=> (trapKind == 3'd1 || trapKind == 3'd2) && !rdWrite && $stable(canSave));

  // R5
  restore_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqOp == 3'd1
    |=> cwp == (($past(cwp) == '0) ? LAST : $past(cwp) - 1'b1));

  // R7
  flush_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqOp == 3'd3
    |=> $stable(cwp) && $stable(canSave) && $stable(canRestore) && !rdWrite);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid && $stable(cwp) && $stable(canSave) && $stable(canRestore));

  // R1
  cwp_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) == 1'b0 |-> (cwp == '0) && !rspValid);

endmodule

// File: tb/regwin_ctl_test.sv
`timescale 1ns/1ps
module regwin_ctl_test;

  localparam int NWIN = 8;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [2:0] reqOp = '0;
  logic [1:0] tgtLow = '0;
  logic [CW-1:0] ldCwp = '0, ldCanSave = '0, ldCanRestore = '0, ldCleanWin = '0, ldOtherWin = '0;
  logic [5:0] ldWstate = '0;
  logic [CW-1:0] cwp, canSave, canRestore, cleanWin, otherWin;
  logic [5:0] wstate;
  logic rspValid, rdWrite;
  logic [2:0] trapKind, trapVec;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  regwin_ctl #(.NWIN(NWIN)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .tgtLow(tgtLow),
    .ldCwp(ldCwp), .ldCanSave(ldCanSave), .ldCanRestore(ldCanRestore),
    .ldCleanWin(ldCleanWin), .ldOtherWin(ldOtherWin), .ldWstate(ldWstate),
    .cwp(cwp), .canSave(canSave), .canRestore(canRestore), .cleanWin(cleanWin),
    .otherWin(otherWin), .wstate(wstate), .rspValid(rspValid), .rdWrite(rdWrite),
    .trapKind(trapKind), .trapVec(trapVec)
  );

  typedef struct packed {
    logic [2:0] op;
    logic [1:0] tgt;
    logic [2:0] lCwp, lCs, lCr, lCw, lOw;
    logic [5:0] lWs;
    logic [2:0] eCwp, eCs, eCr, eKind, eVec;
    logic       eRd;
    logic [3:0] tag;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t TABLE [NV] = '{
    '{3'd4, 2'd0, 3'd0, 3'd6, 3'd0, 3'd6, 3'd0, 6'o51, 3'd0, 3'd6, 3'd0, 3'd0, 3'd0, 1'b0, 4'd9},  // R9
    '{3'd0, 2'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 6'o00, 3'd1, 3'd5, 3'd1, 3'd0, 3'd0, 1'b1, 4'd2},  // R2
    '{3'd0, 2'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 6'o00, 3'd2, 3'd4, 3'd2, 3'd0, 3'd0, 1'b1, 4'd2},  // R2
    '{3'd1, 2'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 6'o00, 3'd1, 3'd5, 3'd1, 3'd0, 3'd0, 1'b1, 4'd5},  // R5
    '{3'd2, 2'd2, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 6'o00, 3'd1, 3'd5, 3'd1, 3'd6, 3'd0, 1'b0, 4'd6},  // R6
    '{3'd2, 2'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 6'o00, 3'd0, 3'd6, 3'd0, 3'd0, 3'd0, 1'b1, 4'd6},  // R6
    '{3'd1, 2'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 6'o00, 3'd7, 3'd6, 3'd0, 3'd3, 3'd1, 1'b0, 4'd5},  // R5 R8
    '{3'd3, 2'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 6'o00, 3'd7, 3'd6, 3'd0, 3'd0, 3'd0, 1'b0, 4'd7},  // R7
    '{3'd4, 2'd0, 3'd7, 3'd0, 3'd6, 3'd6, 3'd0, 6'o51, 3'd7, 3'd0, 3'd6, 3'd0, 3'd0, 1'b0, 4'd9},  // R9
    '{3'd0, 2'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 6'o00, 3'd1, 3'd0, 3'd6, 3'd1, 3'd1, 1'b0, 4'd3},  // R3 wrap
    '{3'd3, 2'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 6'o00, 3'd1, 3'd0, 3'd6, 3'd1, 3'd1, 1'b0, 4'd7},  // R7
    '{3'd4, 2'd0, 3'd6, 3'd0, 3'd5, 3'd7, 3'd1, 6'o51, 3'd6, 3'd0, 3'd5, 3'd0, 3'd0, 1'b0, 4'd9},  // R9
    '{3'd0, 2'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 6'o00, 3'd0, 3'd0, 3'd5, 3'd2, 3'd5, 1'b0, 4'd3},  // R3 R8
    '{3'd1, 2'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 6'o00, 3'd7, 3'd1, 3'd4, 3'd0, 3'd0, 1'b1, 4'd5},  // R5
    '{3'd4, 2'd0, 3'd7, 3'd3, 3'd2, 3'd2, 3'd0, 6'o51, 3'd7, 3'd3, 3'd2, 3'd0, 3'd0, 1'b0, 4'd9},  // R9
    '{3'd0, 2'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 6'o00, 3'd0, 3'd3, 3'd2, 3'd5, 3'd0, 1'b0, 4'd4},  // R4
    '{3'd4, 2'd0, 3'd3, 3'd2, 3'd0, 3'd4, 3'd2, 6'o51, 3'd3, 3'd2, 3'd0, 3'd0, 3'd0, 1'b0, 4'd9},  // R9
    '{3'd1, 2'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 6'o00, 3'd2, 3'd2, 3'd0, 3'd4, 3'd5, 1'b0, 4'd5},  // R5 R8
    '{3'd2, 2'd1, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 6'o00, 3'd2, 3'd2, 3'd0, 3'd6, 3'd0, 1'b0, 4'd6},  // R6 priority
    '{3'd2, 2'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 6'o00, 3'd1, 3'd2, 3'd0, 3'd4, 3'd5, 1'b0, 4'd6},  // R6
    '{3'd3, 2'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 6'o00, 3'd1, 3'd2, 3'd0, 3'd2, 3'd5, 1'b0, 4'd7}   // R7
  };

  function automatic string tagName(input int t);
    case (t)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";   10: return "R10"; default: return "R11";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      finishRun();
    end
  end

  task automatic issue(input vec_t v);
    @(negedge clk);
    reqValid     = 1'b1;
    reqOp        = v.op;
    tgtLow       = v.tgt;
    ldCwp        = v.lCwp;
    ldCanSave    = v.lCs;
    ldCanRestore = v.lCr;
    ldCleanWin   = v.lCw;
    ldOtherWin   = v.lOw;
    ldWstate     = v.lWs;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  initial begin
    // R1: reset values
    repeat (3) @(negedge clk);
    check("R1", "cwp in reset", int'(cwp), 0);
    check("R1", "canSave in reset", int'(canSave), NWIN - 2);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "canRestore", int'(canRestore), 0);
    check("R1", "cleanWin", int'(cleanWin), NWIN - 2);
    check("R1", "otherWin", int'(otherWin), 0);
    check("R1", "wstate", int'(wstate), 0);
    check("R1", "rspValid", int'(rspValid), 0);

    for (int i = 0; i < NV; i++) begin
      string t;
      t = tagName(int'(TABLE[i].tag));
      issue(TABLE[i]);
      // R11: response in the cycle after the request edge
      check("R11", $sformatf("rspValid row %0d", i), int'(rspValid), 1);
      check(t, $sformatf("cwp row %0d", i), int'(cwp), int'(TABLE[i].eCwp));
      check(t, $sformatf("canSave row %0d", i), int'(canSave), int'(TABLE[i].eCs));
      check(t, $sformatf("canRestore row %0d", i), int'(canRestore), int'(TABLE[i].eCr));
      check(t, $sformatf("trapKind row %0d", i), int'(trapKind), int'(TABLE[i].eKind));
      check("R8", $sformatf("trapVec row %0d", i), int'(trapVec), int'(TABLE[i].eVec));
      check(t, $sformatf("rdWrite row %0d", i), int'(rdWrite), int'(TABLE[i].eRd));
      if (i == 0) begin
        // R9: the rest of the loaded state
        check("R9", "cleanWin after load", int'(cleanWin), 6);
        check("R9", "otherWin after load", int'(otherWin), 0);
        check("R9", "wstate after load", int'(wstate), 6'o51);
      end
      @(negedge clk);
      // R11: response lasts one cycle
      check("R11", $sformatf("rspValid drop row %0d", i), int'(rspValid), 0);
    end

    // R10: idle and undefined op codes do nothing
    begin
      vec_t v;
      v = '0;
      v.op = 3'd7;
      v.lCwp = 3'd5;
      issue(v);
      check("R10", "rspValid op7", int'(rspValid), 0);
      check("R10", "cwp op7", int'(cwp), 1);
      check("R10", "canSave op7", int'(canSave), 2);
      check("R10", "otherWin op7", int'(otherWin), 2);
      v.op = 3'd5;
      issue(v);
      check("R10", "rspValid op5", int'(rspValid), 0);
      check("R10", "cwp op5", int'(cwp), 1);
    end
    repeat (3) @(negedge clk);
    check("R10", "cwp idle", int'(cwp), 1);
    check("R10", "rdWrite idle", int'(rdWrite), 0);

    // R1: reset again mid-run
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "cwp after reset", int'(cwp), 0);
    check("R1", "canSave after reset", int'(canSave), NWIN - 2);
    check("R1", "otherWin after reset", int'(otherWin), 0);

    finishRun();
  end

endmodule